// File: doc/BRIEF.md
# Accumulator Processor Core with Multi-Cycle Control

This block is a small accumulator processor. It runs one instruction at a time, in strict order, through a fetch, decode and execute sequence. One memory holds both the program and its data, and the core reaches it through a single port. Every transfer goes through an address holding register and a data holding register. A control state machine moves values between the program counter, the instruction register, the accumulator and the two holding registers, one step per clock cycle.

The memory is synchronous with one cycle of read latency. The core raises the read strobe for one cycle with the address on the address bus, then captures the returned word in the following cycle. A write is one cycle with the write strobe, the address and the data driven together.

An instruction word is 16 bits. The top 4 bits select the operation and the low 12 bits are a memory address. The core loads, stores, adds, subtracts, branches unconditionally, branches on a zero accumulator and branches on a non-negative accumulator. A stop instruction parks the core and raises a halted flag until the next reset.

Top module: `acc_core`

## Requirements
- R1: While the synchronous reset `rst` is high, every internal register is cleared: `mem_addr` is 0, both strobes are low and `halted` is low. In the first cycle after release the core reads address 0.
- R2: Each instruction is fetched in the same way. The program counter is copied to the address register. A read strobe lasting exactly one cycle is driven with that address. The word returned in the next cycle goes to the data register and then to the instruction register. The program counter then grows by exactly one. Bits [15:12] of the word are the opcode and bits [11:0] are the operand address.
- R3: Opcode 1 (load) reads the word at the operand address and places it in the accumulator.
- R4: Opcode 2 (store) writes the accumulator to the operand address in a single write-strobe cycle, with `mem_wdata` equal to the accumulator.
- R5: Opcode 3 (add) and opcode 4 (subtract) read the word at the operand address and replace the accumulator with the sum or the difference (accumulator minus word), modulo 2^16.
- R6: Opcode 5 always loads the program counter with the operand address.
- R7: Opcode 6 loads the program counter with the operand address only when the accumulator is zero. Otherwise execution continues in sequence.
- R8: Opcode 7 loads the program counter with the operand address only when accumulator bit 15 is 0. Otherwise execution continues in sequence.
- R9: Opcode 0 (stop) raises `halted`. It then stays high, with no further strobes, until reset.
- R10: Opcodes 8 to 15 change neither the accumulator nor memory. The next instruction is fetched from the following address.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle, and a read strobe never lasts longer than one cycle.
- R12: Cycle cost per instruction, from the start of its fetch to the start of the next fetch: 10 for load, add and subtract; 9 for store; 7 for the three branches, taken or not; 6 for opcodes 8 to 15. `halted` rises 6 cycles after the stop instruction's fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address, from the address register |
| mem_rd | output | 1 | Read strobe; data arrives in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, from the data register |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
Assertions check the following on every cycle:
- the strobes never overlap, and a read lasts one cycle;
- a fetch read uses the program counter as its address, and the counter steps by exactly one after the fetch;
- store data equals the accumulator;
- the accumulator changes only in its write-back step;
- `halted` is sticky and silences the bus.

Only the bench scenarios can show that the arithmetic results are right, that each branch is taken or skipped according to the accumulator value, that the cycle counts are correct, and that the unused opcodes leave memory and the accumulator untouched. The bench sweeps value pairs for add and subtract, crosses every branch kind with boundary accumulator values, and runs every unused opcode.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OP_STOP  = 0;
    localparam int OP_LOAD  = 1;
    localparam int OP_STORE = 2;
    localparam int OP_ADD   = 3;
    localparam int OP_SUB   = 4;
    localparam int OP_JMP   = 5;
    localparam int OP_JZ    = 6;
    localparam int OP_JNN   = 7;

    typedef enum logic [3:0] {
        ST_F_MAR, ST_F_RD, ST_F_MDR, ST_F_CIR, ST_F_INC, ST_DEC,
        ST_X_MAR, ST_X_RD, ST_X_MDR, ST_X_ACC,
        ST_S_MAR, ST_S_MDR, ST_S_WR,
        ST_BR, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        K_STOP, K_MEMRD, K_STORE, K_BRANCH, K_NOP
    } kind_e;

    typedef enum logic [1:0] {
        ALU_PASS, ALU_ADD, ALU_SUB
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_ALWAYS, BR_ZERO, BR_NONNEG
    } br_cond_e;

    typedef struct packed {
        kind_e    kind;
        alu_op_e  alu_op;
        br_cond_e br_cond;
    } dec_t;

endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
    import acc_core_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);

    always_comb begin
        dec = '{kind: K_NOP, alu_op: ALU_PASS, br_cond: BR_ALWAYS};
        case (int'(opcode))
            OP_STOP:  dec.kind = K_STOP;
            OP_LOAD:  begin dec.kind = K_MEMRD; dec.alu_op = ALU_PASS; end
            OP_STORE: dec.kind = K_STORE;
            OP_ADD:   begin dec.kind = K_MEMRD; dec.alu_op = ALU_ADD; end
            OP_SUB:   begin dec.kind = K_MEMRD; dec.alu_op = ALU_SUB; end
            OP_JMP:   begin dec.kind = K_BRANCH; dec.br_cond = BR_ALWAYS; end
            OP_JZ:    begin dec.kind = K_BRANCH; dec.br_cond = BR_ZERO; end
            OP_JNN:   begin dec.kind = K_BRANCH; dec.br_cond = BR_NONNEG; end
            default:  dec.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/acc_branch_eval.sv
module acc_branch_eval
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  br_cond_e          cond,
    input  logic [DATA_W-1:0] acc,
    output logic              take
);

    always_comb begin
        case (cond)
            BR_ZERO:   take = (acc == '0);
            BR_NONNEG: take = ~acc[DATA_W-1];
            default:   take = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] alu_y,
    input  logic              br_take,
    output logic [OPC_W-1:0]  opcode,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] mdr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              halted
);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
        logic [DATA_W-1:0] cir;
        logic [DATA_W-1:0] acc;
    } regs_t;

    regs_t q, d;
    logic [ADDR_W-1:0] operand;

    assign operand   = q.cir[ADDR_W-1:0];
    assign opcode    = q.cir[DATA_W-1 -: OPC_W];
    assign acc       = q.acc;
    assign mdr       = q.mdr;
    assign mem_addr  = q.mar;
    assign mem_wdata = q.mdr;
    assign halted    = (q.st == ST_HALT);

    always_comb begin
        d      = q;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        case (q.st)
            ST_F_MAR: begin d.mar = q.pc;      d.st = ST_F_RD;  end
            ST_F_RD:  begin mem_rd = 1'b1;     d.st = ST_F_MDR; end
            ST_F_MDR: begin d.mdr = mem_rdata; d.st = ST_F_CIR; end
            ST_F_CIR: begin d.cir = q.mdr;     d.st = ST_F_INC; end
            ST_F_INC: begin d.pc = q.pc + 1'b1; d.st = ST_DEC;  end
            ST_DEC: begin
                case (dec.kind)
                    K_STOP:   d.st = ST_HALT;
                    K_MEMRD:  d.st = ST_X_MAR;
                    K_STORE:  d.st = ST_S_MAR;
                    K_BRANCH: d.st = ST_BR;
                    default:  d.st = ST_F_MAR;
                endcase
            end
            ST_X_MAR: begin d.mar = operand;   d.st = ST_X_RD;  end
            ST_X_RD:  begin mem_rd = 1'b1;     d.st = ST_X_MDR; end
            ST_X_MDR: begin d.mdr = mem_rdata; d.st = ST_X_ACC; end
            ST_X_ACC: begin d.acc = alu_y;     d.st = ST_F_MAR; end
            ST_S_MAR: begin d.mar = operand;   d.st = ST_S_MDR; end
            ST_S_MDR: begin d.mdr = q.acc;     d.st = ST_S_WR;  end
            ST_S_WR:  begin mem_wr = 1'b1;     d.st = ST_F_MAR; end
            ST_BR: begin
                if (br_take) d.pc = operand;
                d.st = ST_F_MAR;
            end
            ST_HALT:  d.st = ST_HALT;
            default:  d.st = ST_F_MAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= ST_F_MAR;
            q.pc  <= '0;
            q.mar <= '0;
            q.mdr <= '0;
            q.cir <= '0;
            q.acc <= '0;
        end else begin
            q <= d;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R11
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd); // R11
    AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && q.st == ST_F_RD) |-> (mem_addr == q.pc)); // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_F_INC) |=> (q.pc == $past(q.pc) + 1'b1)); // R2
    AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata == q.acc)); // R4
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q.st != ST_X_ACC) |=> $stable(q.acc)); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_rd && !mem_wr)); // R9

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    dec_t              dec;
    logic [OPC_W-1:0]  opcode;
    logic [DATA_W-1:0] acc, mdr, alu_y;
    logic              br_take;

    acc_decoder #(.OPC_W(OPC_W)) i_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    acc_alu #(.DATA_W(DATA_W)) i_alu (
        .op (dec.alu_op),
        .a  (acc),
        .b  (mdr),
        .y  (alu_y)
    );

    acc_branch_eval #(.DATA_W(DATA_W)) i_br (
        .cond (dec.br_cond),
        .acc  (acc),
        .take (br_take)
    );

    acc_ctrl #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .dec       (dec),
        .alu_y     (alu_y),
        .br_take   (br_take),
        .opcode    (opcode),
        .acc       (acc),
        .mdr       (mdr),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .halted    (halted)
    );

endmodule

// File: tb/test_acc_core.sv
module test_acc_core;

    localparam int MEM_N = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] img [MEM_N];
    logic [15:0] mem [MEM_N];
    logic        load_req = 1'b0;
    logic [11:0] rd_log [8];
    int          rd_n, wr_n, both_n, halt_bus_n;
    logic [11:0] wr_first;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    acc_core i_acc_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted)
    );

    always @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= img[i];
            rd_n <= 0; wr_n <= 0; both_n <= 0; halt_bus_n <= 0;
            mem_rdata <= '0;
        end else begin
            if (mem_rd) begin
                mem_rdata <= mem[mem_addr[7:0]];
                if (rd_n < 8) rd_log[rd_n] <= mem_addr;
                rd_n <= rd_n + 1;
            end
            if (mem_wr) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                if (wr_n == 0) wr_first <= mem_addr;
                wr_n <= wr_n + 1;
            end
            if (mem_rd && mem_wr) both_n <= both_n + 1;
            if (halted && (mem_rd || mem_wr)) halt_bus_n <= halt_bus_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input int op, input int a);
        return {4'(op), 12'(a)};
    endfunction

    task automatic clear_img();
        for (int i = 0; i < MEM_N; i++) img[i] = 16'h0000;
    endtask

    // Reset, load memory, run to halt; returns cycles counted from release.
    task automatic run_prog(output int cyc);
        @(negedge clk);
        rst = 1'b1; load_req = 1'b1;
        @(posedge clk); @(negedge clk);
        load_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(!mem_rd && !mem_wr && mem_addr == 0 && !halted, "R1 reset state",
            {mem_rd, mem_wr, halted, mem_addr}, 0);
        rst = 1'b0;
        cyc = 0;
        @(posedge clk); cyc++; @(negedge clk);
        chk(mem_rd && mem_addr == 0, "R1 first fetch at 0", {mem_rd, mem_addr}, 16'h1000);
        while (!halted && cyc < 2000) begin
            @(posedge clk); cyc++; @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk(halted && halt_bus_n == 0, "R9 halt sticky and quiet", halt_bus_n, 0);
        chk(both_n == 0, "R11 strobes exclusive", both_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] a, b, v;
        bit take;

        // Arithmetic sweep: load, store, add, subtract
        for (int i = 0; i < 16; i++) begin
            a = 16'(i * 12345 + ((i & 1) << 15));
            b = 16'(65535 - i * 777);
            clear_img();
            img[0] = ins(1, 100); img[1] = ins(2, 104);
            img[2] = ins(3, 101); img[3] = ins(2, 102);
            img[4] = ins(1, 100); img[5] = ins(4, 101);
            img[6] = ins(2, 103); img[7] = ins(0, 0);
            img[100] = a; img[101] = b;
            run_prog(cyc);
            chk(mem[104] == a, "R3 load value", mem[104], a);
            chk(mem[102] == 16'(a + b), "R5 add result", mem[102], 16'(a + b));
            chk(mem[103] == 16'(a - b), "R5 sub result", mem[103], 16'(a - b));
            chk(wr_n == 3 && wr_first == 104, "R4 store address/count",
                {wr_n[3:0], wr_first}, {4'd3, 12'd104});
            chk(cyc == 73, "R12 cycles arithmetic program", cyc, 73);
            chk(rd_log[0] == 0 && rd_log[1] == 100 && rd_log[2] == 1,
                "R2 fetch/operand read order", {rd_log[1], rd_log[2]}, {12'd100, 12'd1});
        end

        // Branch sweep
        for (int op = 5; op <= 7; op++) begin
            for (int k = 0; k < 6; k++) begin
                case (k)
                    0: v = 16'h0000; 1: v = 16'h0001; 2: v = 16'h7FFF;
                    3: v = 16'h8000; 4: v = 16'hFFFF; default: v = 16'h0005;
                endcase
                take = (op == 5) || (op == 6 && v == 0) || (op == 7 && !v[15]);
                clear_img();
                img[0] = ins(1, 100); img[1] = ins(op, 5);
                img[2] = ins(1, 101); img[3] = ins(2, 102); img[4] = ins(0, 0);
                img[5] = ins(1, 103); img[6] = ins(2, 102); img[7] = ins(0, 0);
                img[100] = v; img[101] = 16'h1111; img[103] = 16'h2222;
                run_prog(cyc);
                if (op == 5)
                    chk(mem[102] == 16'h2222, "R6 jump taken", mem[102], 16'h2222);
                else if (op == 6)
                    chk(mem[102] == (take ? 16'h2222 : 16'h1111), "R7 zero branch",
                        mem[102], take ? 16'h2222 : 16'h1111);
                else
                    chk(mem[102] == (take ? 16'h2222 : 16'h1111), "R8 non-negative branch",
                        mem[102], take ? 16'h2222 : 16'h1111);
                chk(cyc == 42, "R12 cycles branch program", cyc, 42);
            end
        end

        // Unused opcodes
        for (int op = 8; op <= 15; op++) begin
            v = 16'h0A5A + 16'(op);
            clear_img();
            img[0] = ins(1, 100); img[1] = ins(op, 101);
            img[2] = ins(2, 102); img[3] = ins(0, 0);
            img[100] = v; img[101] = 16'hBEEF;
            run_prog(cyc);
            chk(mem[102] == v, "R10 accumulator kept", mem[102], v);
            chk(mem[101] == 16'hBEEF && wr_n == 1, "R10 memory untouched",
                mem[101], 16'hBEEF);
            chk(cyc == 31, "R12 cycles unused opcode", cyc, 31);
        end

        // Immediate stop
        clear_img();
        run_prog(cyc);
        chk(cyc == 6 && rd_n == 1, "R9 stop at address 0", cyc, 6);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule